// File: doc/BRIEF.md
# Load-Store Address Disambiguation Unit

This unit sits between the address-generation stage and the data memory port of an out-of-order core. Every load and store is entered into the unit at issue time, in program order, with its reorder-buffer tag. The effective address is delivered later, by tag, once it has been computed. The unit then decides, cycle by cycle, which load may start its memory access. A load is held back while any older store in the unit either has no address yet or has exactly the same address.

Stores never leave the unit on their own. A store entry is released toward memory, with its address and tag, only when the reorder buffer signals that the store has committed. That release also removes the entry, which can unblock younger loads. A flush empties the unit in one cycle. A full flag tells the issue stage to hold further entries.

Top module: `ldst_disambig`

## Requirements
- R1: After reset the unit holds no entries: `full`, `ld_grant_valid` and `rel_valid` are all 0.
- R2: An entry is taken when `alloc_valid` is 1 and the unit is not full. `alloc_is_store` = 1 marks a store and 0 marks a load. `full` is 1 exactly when DEPTH entries are held. An allocation offered while full is dropped, and a later address or grant for that tag never appears.
- R3: A load whose address is known and which has no older store is granted. `ld_grant_valid` is 1 with its tag and address in the cycle after its first cycle of eligibility while `mem_ready` is 1. The load entry is then removed, so the grant lasts one cycle.
- R4: A load is not granted while an older uncommitted store in the unit holds the same address.
- R5: A load is not granted while an older store in the unit has no address yet.
- R6: An older store with a different address does not block a load. A younger store does not block it either, even when its address is the same.
- R7: No load is granted in the cycle after one in which `mem_ready` was 0.
- R8: When several loads are eligible, the oldest in allocation order is granted first, at one grant per cycle, whatever order their addresses arrived in.
- R9: A `commit_valid` pulse whose tag matches a held store gives `rel_valid` = 1 in the next cycle, with that store's tag and address. The store entry is removed at the same edge, and loads that it blocked become eligible.
- R10: `flush` removes every entry at the next edge. It has priority over allocation, commit and grant in the same cycle, so `ld_grant_valid` and `rel_valid` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Enter a new memory operation (program order) |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_tag | input | TAG_W | Reorder-buffer tag of the new operation |
| full | output | 1 | All DEPTH entries held; allocation stalls |
| ea_valid | input | 1 | An effective address is delivered |
| ea_tag | input | TAG_W | Tag of the operation whose address is delivered |
| ea_addr | input | ADDR_W | Effective address |
| commit_valid | input | 1 | Reorder buffer commits a store |
| commit_tag | input | TAG_W | Tag of the committed store |
| mem_ready | input | 1 | Memory port can accept a load next cycle |
| ld_grant_valid | output | 1 | A load is sent to memory |
| ld_grant_tag | output | TAG_W | Tag of the granted load |
| ld_grant_addr | output | ADDR_W | Address of the granted load |
| rel_valid | output | 1 | A committed store is released to memory |
| rel_tag | output | TAG_W | Tag of the released store |
| rel_addr | output | ADDR_W | Address of the released store |
| flush | input | 1 | Discard all entries |

## Verification
Loads are tried alone, behind an older store at the same address, and behind an older store whose address is still missing. They are also tried with an older store at a different address and with a younger store at the same address. These cases separate a true address match from age ordering and from the unknown-address wait. A group of loads whose addresses arrive in reverse order shows that selection follows allocation age and not address arrival. Runs with `mem_ready` low, a unit filled to capacity and a flush that coincides with a pending grant and a commit show the stall paths and the priority of flush.

// File: rtl/ldst_disambig_pkg.sv
// Package: shared types for the load-store disambiguation unit.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ldst_disambig_pkg;

    // Kind of memory operation held in an entry
    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } mem_kind_e;

endpackage

// File: rtl/lsd_free_slot.sv
// Module: lsd_free_slot
// Finds the lowest-numbered unoccupied entry of the unit.
// Assumes: DEPTH >= 2; purely combinational.
module lsd_free_slot #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] occupied,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Priority search from the top so the lowest free index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lsd_age_matrix.sv
// Module: lsd_age_matrix
// Keeps relative age between entries: older[r][c] = 1 means entry c was
// allocated before entry r. Bits are only meaningful where both entries are
// occupied; the consumer masks with the occupancy vector.
// Assumes: at most one allocation per cycle, flush clears everything.
module lsd_age_matrix #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        alloc_en,
    input  logic [IDX_W-1:0]            alloc_idx,
    input  logic [DEPTH-1:0]            occupied,
    output logic [DEPTH-1:0][DEPTH-1:0] older
);

    // New entry is younger than every occupied entry; clear its column
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            older <= '0;
        end else if (alloc_en) begin
            for (int r = 0; r < DEPTH; r++) begin
                older[r][alloc_idx] <= 1'b0;
            end
            older[alloc_idx] <= occupied;
        end
    end

endmodule

// File: rtl/lsd_load_select.sv
// Module: lsd_load_select
// Decides which loads may access memory and picks the oldest of them.
// A load is eligible when its address is known and every older store in the
// unit has a known address that differs from the load's address.
// Assumes: older[][] from lsd_age_matrix; purely combinational.
module lsd_load_select #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic [DEPTH-1:0]             valid,
    input  logic [DEPTH-1:0]             is_store,
    input  logic [DEPTH-1:0]             ea_ok,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic [DEPTH-1:0][DEPTH-1:0]  older,
    output logic [DEPTH-1:0]             pick,
    output logic                         any_pick
);

    logic [DEPTH-1:0] elig;

    for (genvar i = 0; i < DEPTH; i++) begin : g_load
        logic hazard;

        // Scan older stores for a missing or equal address
        always_comb begin
            hazard = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (older[i][j] && valid[j] && is_store[j] &&
                    (!ea_ok[j] || addr[j] == addr[i])) begin
                    hazard = 1'b1;
                end
            end
        end

        // Load ready to go when addressed and free of hazards
        assign elig[i] = valid[i] && !is_store[i] && ea_ok[i] && !hazard;

        // Oldest eligible load: no eligible load is older than this one
        assign pick[i] = elig[i] && !(|(elig & older[i] & valid));
    end

    assign any_pick = |pick;

endmodule

// File: rtl/ldst_disambig.sv
// Module: ldst_disambig (top)
// Holds in-flight loads and stores in allocation (program) order, collects
// their effective addresses by tag, grants the oldest hazard-free load to the
// memory port and releases stores only on commit.
// Assumes: tags of in-flight operations are unique; an address is never
// delivered in the same cycle its operation is allocated; a committed store
// already has its address.
module ldst_disambig
    import ldst_disambig_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              full,
    input  logic              ea_valid,
    input  logic [TAG_W-1:0]  ea_tag,
    input  logic [ADDR_W-1:0] ea_addr,
    input  logic              commit_valid,
    input  logic [TAG_W-1:0]  commit_tag,
    input  logic              mem_ready,
    output logic              ld_grant_valid,
    output logic [TAG_W-1:0]  ld_grant_tag,
    output logic [ADDR_W-1:0] ld_grant_addr,
    output logic              rel_valid,
    output logic [TAG_W-1:0]  rel_tag,
    output logic [ADDR_W-1:0] rel_addr,
    input  logic              flush
);

    localparam int IDX_W = $clog2(DEPTH);

    // Entry storage
    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0]             ea_ok_q;
    mem_kind_e                    kind_q [DEPTH];
    logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;

    logic [DEPTH-1:0]            is_store;
    logic [DEPTH-1:0]            ea_hit;
    logic [DEPTH-1:0]            commit_hit;
    logic [DEPTH-1:0]            pick_vec;
    logic [DEPTH-1:0][DEPTH-1:0] older;
    logic                        any_pick;
    logic                        slot_found;
    logic [IDX_W-1:0]            slot_idx;
    logic                        alloc_go;
    logic                        grant_go;
    logic [TAG_W-1:0]            pick_tag;
    logic [ADDR_W-1:0]           pick_addr;
    logic [ADDR_W-1:0]           commit_addr;

    // Per-entry tag matches for address delivery and store commit
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        assign is_store[i]   = (kind_q[i] == KIND_STORE);
        assign ea_hit[i]     = ea_valid && valid_q[i] && (tag_q[i] == ea_tag);
        assign commit_hit[i] = commit_valid && valid_q[i] && is_store[i] &&
                               (tag_q[i] == commit_tag);
    end

    lsd_free_slot #(.DEPTH(DEPTH)) u_slot (
        .occupied (valid_q),
        .found    (slot_found),
        .idx      (slot_idx)
    );

    lsd_age_matrix #(.DEPTH(DEPTH)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc_en  (alloc_go),
        .alloc_idx (slot_idx),
        .occupied  (valid_q),
        .older     (older)
    );

    lsd_load_select #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_sel (
        .valid    (valid_q),
        .is_store (is_store),
        .ea_ok    (ea_ok_q),
        .addr     (addr_q),
        .older    (older),
        .pick     (pick_vec),
        .any_pick (any_pick)
    );

    assign full     = !slot_found;
    assign alloc_go = alloc_valid && slot_found && !flush;
    assign grant_go = mem_ready && any_pick && !flush;

    // Gather the picked load and the committing store (one-hot OR mux)
    always_comb begin
        pick_tag    = '0;
        pick_addr   = '0;
        commit_addr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick_vec[i]) begin
                pick_tag  = pick_tag | tag_q[i];
                pick_addr = pick_addr | addr_q[i];
            end
            if (commit_hit[i]) begin
                commit_addr = commit_addr | addr_q[i];
            end
        end
    end

    // Entry lifecycle: allocate, record address, retire on grant or commit
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            ea_ok_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                kind_q[i] <= KIND_LOAD;
            end
            tag_q  <= '0;
            addr_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((grant_go && pick_vec[i]) || commit_hit[i]) begin
                    valid_q[i] <= 1'b0;
                end
                if (ea_hit[i]) begin
                    ea_ok_q[i] <= 1'b1;
                    addr_q[i]  <= ea_addr;
                end
                if (alloc_go && slot_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    ea_ok_q[i] <= 1'b0;
                    kind_q[i]  <= alloc_is_store ? KIND_STORE : KIND_LOAD;
                    tag_q[i]   <= alloc_tag;
                end
            end
        end
    end

    // Registered load grant toward the memory port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_grant_valid <= 1'b0;
            ld_grant_tag   <= '0;
            ld_grant_addr  <= '0;
        end else begin
            ld_grant_valid <= grant_go;
            ld_grant_tag   <= pick_tag;
            ld_grant_addr  <= pick_addr;
        end
    end

    // Registered store release on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid <= 1'b0;
            rel_tag   <= '0;
            rel_addr  <= '0;
        end else begin
            rel_valid <= (|commit_hit) && !flush;
            rel_tag   <= commit_tag;
            rel_addr  <= commit_addr;
        end
    end

endmodule

// File: rtl/ldst_disambig_chk.sv
// Module: ldst_disambig_chk
// Concurrent checks on the disambiguation unit, attached by bind.
// Assumes: synchronous active-low reset; all checks disabled during reset.
module ldst_disambig_chk #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             mem_ready,
    input logic             commit_valid,
    input logic [TAG_W-1:0] commit_tag,
    input logic             ld_grant_valid,
    input logic             rel_valid,
    input logic [TAG_W-1:0] rel_tag,
    input logic             full,
    input logic [DEPTH-1:0] valid_q,
    input logic [DEPTH-1:0] pick
);

    // R7: a grant only follows a cycle in which the port was free
    p_grant_needs_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_grant_valid |-> $past(mem_ready));

    // R9: a release only follows a commit and carries its tag
    p_release_follows_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> ($past(commit_valid) && rel_tag == $past(commit_tag)));

    // R10: flush empties the unit and silences both outputs
    p_flush_quiets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!ld_grant_valid && !rel_valid && valid_q == '0 && !full));

    // R8: at most one load is selected per cycle
    p_single_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

    // R3: a picked load with a free port is gone from the unit next cycle
    p_grant_retires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && !flush && pick != '0) |=> ld_grant_valid);

endmodule

bind ldst_disambig ldst_disambig_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .mem_ready      (mem_ready),
    .commit_valid   (commit_valid),
    .commit_tag     (commit_tag),
    .ld_grant_valid (ld_grant_valid),
    .rel_valid      (rel_valid),
    .rel_tag        (rel_tag),
    .full           (full),
    .valid_q        (valid_q),
    .pick           (pick_vec)
);

// File: tb/sim_ldst_disambig.sv
`timescale 1ns/1ps
// Bench: directed scenarios for ldst_disambig, one task per scenario.
module sim_ldst_disambig;

    localparam int TW = 5;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          alloc_valid, alloc_is_store;
    logic [TW-1:0] alloc_tag;
    logic          full;
    logic          ea_valid;
    logic [TW-1:0] ea_tag;
    logic [AW-1:0] ea_addr;
    logic          commit_valid;
    logic [TW-1:0] commit_tag;
    logic          mem_ready;
    logic          ld_grant_valid;
    logic [TW-1:0] ld_grant_tag;
    logic [AW-1:0] ld_grant_addr;
    logic          rel_valid;
    logic [TW-1:0] rel_tag;
    logic [AW-1:0] rel_addr;
    logic          flush;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ldst_disambig #(.DEPTH(8), .TAG_W(TW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_tag(alloc_tag), .full(full),
        .ea_valid(ea_valid), .ea_tag(ea_tag), .ea_addr(ea_addr),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .mem_ready(mem_ready),
        .ld_grant_valid(ld_grant_valid), .ld_grant_tag(ld_grant_tag),
        .ld_grant_addr(ld_grant_addr),
        .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_addr(rel_addr),
        .flush(flush)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_grant(input string req, input logic v,
                             input logic [TW-1:0] t, input logic [AW-1:0] a);
        chk(req, "ld_grant_valid", 64'(ld_grant_valid), 64'(v));
        if (v) begin
            chk(req, "ld_grant_tag", 64'(ld_grant_tag), 64'(t));
            chk(req, "ld_grant_addr", 64'(ld_grant_addr), 64'(a));
        end
    endtask

    task automatic chk_rel(input string req, input logic v,
                           input logic [TW-1:0] t, input logic [AW-1:0] a);
        chk(req, "rel_valid", 64'(rel_valid), 64'(v));
        if (v) begin
            chk(req, "rel_tag", 64'(rel_tag), 64'(t));
            chk(req, "rel_addr", 64'(rel_addr), 64'(a));
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; alloc_is_store = 0; alloc_tag = '0;
        ea_valid = 0; ea_tag = '0; ea_addr = '0;
        commit_valid = 0; commit_tag = '0; flush = 0;
    endtask

    // One clock edge, then sample just after it and drop pulse inputs
    task automatic step();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic drive_alloc(input logic st, input logic [TW-1:0] t);
        alloc_valid = 1; alloc_is_store = st; alloc_tag = t;
    endtask

    task automatic drive_ea(input logic [TW-1:0] t, input logic [AW-1:0] a);
        ea_valid = 1; ea_tag = t; ea_addr = a;
    endtask

    task automatic drive_commit(input logic [TW-1:0] t);
        commit_valid = 1; commit_tag = t;
    endtask

    task automatic t_reset();
        chk("R1", "full", 64'(full), 64'(0));
        chk("R1", "ld_grant_valid", 64'(ld_grant_valid), 64'(0));
        chk("R1", "rel_valid", 64'(rel_valid), 64'(0));
    endtask

    task automatic t_lone_load();
        drive_alloc(0, 5'd1); step();
        drive_ea(5'd1, 32'h100); step();
        chk_grant("R3", 0, '0, '0);
        step();
        chk_grant("R3", 1, 5'd1, 32'h100);
        step();
        chk_grant("R3", 0, '0, '0);
    endtask

    task automatic t_same_addr();
        drive_alloc(1, 5'd2); step();
        drive_alloc(0, 5'd3); step();
        drive_ea(5'd2, 32'h200); step();
        drive_ea(5'd3, 32'h200); step();
        for (int i = 0; i < 4; i++) begin
            chk_grant("R4", 0, '0, '0);
            step();
        end
        drive_commit(5'd2); step();
        chk_rel("R9", 1, 5'd2, 32'h200);
        chk_grant("R4", 0, '0, '0);
        step();
        chk_grant("R9", 1, 5'd3, 32'h200);
        chk_rel("R9", 0, '0, '0);
        step();
        chk_grant("R9", 0, '0, '0);
    endtask

    task automatic t_unknown_store();
        drive_alloc(1, 5'd4); step();
        drive_alloc(0, 5'd5); step();
        drive_ea(5'd5, 32'h300); step();
        for (int i = 0; i < 3; i++) begin
            chk_grant("R5", 0, '0, '0);
            step();
        end
        drive_ea(5'd4, 32'h400); step();
        chk_grant("R5", 0, '0, '0);
        step();
        chk_grant("R6", 1, 5'd5, 32'h300);
        drive_commit(5'd4); step();
        chk_rel("R9", 1, 5'd4, 32'h400);
    endtask

    task automatic t_younger_store();
        drive_alloc(0, 5'd6); step();
        drive_alloc(1, 5'd7); step();
        drive_ea(5'd6, 32'h500); step();
        drive_ea(5'd7, 32'h500); step();
        chk_grant("R6", 1, 5'd6, 32'h500);
        drive_commit(5'd7); step();
        chk_rel("R9", 1, 5'd7, 32'h500);
    endtask

    task automatic t_port_busy();
        mem_ready = 0;
        drive_alloc(0, 5'd8); step();
        drive_ea(5'd8, 32'h600); step();
        for (int i = 0; i < 3; i++) begin
            chk_grant("R7", 0, '0, '0);
            step();
        end
        mem_ready = 1; step();
        chk_grant("R7", 1, 5'd8, 32'h600);
        step();
        chk_grant("R7", 0, '0, '0);
    endtask

    task automatic t_oldest_first();
        mem_ready = 0;
        drive_alloc(0, 5'd9);  step();
        drive_alloc(0, 5'd10); step();
        drive_alloc(0, 5'd11); step();
        drive_ea(5'd11, 32'hB0); step();
        drive_ea(5'd10, 32'hA0); step();
        drive_ea(5'd9,  32'h90); step();
        mem_ready = 1; step();
        chk_grant("R8", 1, 5'd9, 32'h90);
        step();
        chk_grant("R8", 1, 5'd10, 32'hA0);
        step();
        chk_grant("R8", 1, 5'd11, 32'hB0);
        step();
        chk_grant("R8", 0, '0, '0);
    endtask

    task automatic t_full_and_flush();
        for (int t = 12; t < 20; t++) begin
            drive_alloc(0, TW'(t)); step();
            if (t == 18) chk("R2", "full at 7", 64'(full), 64'(0));
        end
        chk("R2", "full at 8", 64'(full), 64'(1));
        drive_alloc(0, 5'd20); step();
        drive_ea(5'd20, 32'hC00); step();
        for (int i = 0; i < 3; i++) begin
            chk_grant("R2", 0, '0, '0);
            step();
        end
        flush = 1; step();
        chk("R10", "full after flush", 64'(full), 64'(0));
        chk_grant("R10", 0, '0, '0);
        drive_ea(5'd12, 32'h12); step();
        step();
        chk_grant("R10", 0, '0, '0);
        drive_alloc(0, 5'd21); step();
        drive_ea(5'd21, 32'h800); step();
        step();
        chk_grant("R2", 1, 5'd21, 32'h800);
    endtask

    task automatic t_flush_priority();
        drive_alloc(0, 5'd22); step();
        drive_alloc(1, 5'd23); step();
        drive_ea(5'd22, 32'h700); step();
        flush = 1;
        drive_commit(5'd23);
        step();
        chk_grant("R10", 0, '0, '0);
        chk_rel("R10", 0, '0, '0);
        chk("R10", "full", 64'(full), 64'(0));
        step();
        chk_grant("R10", 0, '0, '0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        rst_n = 0;
        mem_ready = 1;
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        t_reset();
        t_lone_load();
        t_same_addr();
        t_unknown_store();
        t_younger_store();
        t_port_busy();
        t_oldest_first();
        t_full_and_flush();
        t_flush_priority();
        report();
        $finish;
    end

endmodule